// File: doc/BRIEF.md
# Prescaled I2C Serial Clock Generator

This block produces the serial clock of an I2C master from a fast input clock. A programmable prescaler first divides the input clock into a slower internal tick, the module clock. The serial clock then spends a programmable number of module-clock cycles low and another programmable number high. Each of the two phases is lengthened by a fixed stretch that depends on the prescaler setting: seven cycles when the prescaler value is zero, six when it is one and five for any larger value. A period therefore lasts ((LOW + s) + (HIGH + s)) x (PSC + 1) input-clock cycles. In normal use the prescaler is chosen so that the module clock lands between 7 MHz and 12 MHz.

Software programs the prescaler, low-count and high-count registers through a plain register port while a run bit in the mode register is 0. Setting the run bit starts the clock with a low phase. Clearing it returns the line to idle-high. Registers written while the clock runs are picked up at the next phase boundary, so a phase in progress is never cut short or stretched. Two one-cycle strobes mark the start of each low phase and each high phase. A byte engine uses them to place data and sample bits.

Top module: `scl_clkgen`

## Requirements
- R1: Register map: prescaler at 0x30, low count at 0x0C, high count at 0x10, mode at 0x24 with the run bit at bit 5. All registers read back the value written and reset to 0.
- R2: A write to any other address changes no register, and reads of other addresses return 0. Mode bits other than bit 5 are not stored and read as 0.
- R3: While the run bit is 0, `scl` is 1 and both strobes stay 0.
- R4: Setting the run bit starts a low phase: `scl` falls, and `scl_low_start` is 1 in that same cycle.
- R5: The stretch s is 7 for PSC = 0, 6 for PSC = 1 and 5 for PSC >= 2. The full period is (LOW + HIGH + 2s) x (PSC + 1) input cycles.
- R6: A low phase lasts (LOW + s) x (PSC + 1) input-clock cycles.
- R7: A high phase lasts (HIGH + s) x (PSC + 1) input-clock cycles.
- R8: Each strobe is one cycle long and the two never coincide. `scl_low_start` is 1 exactly when `scl` falls, and `scl_high_start` is 1 when `scl` rises while running.
- R9: A register written while running leaves the phase in progress unchanged and applies from the next phase boundary.
- R10: Clearing the run bit mid-phase returns `scl` to 1 two cycles after the write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| scl | output | 1 | Serial clock |
| scl_low_start | output | 1 | One-cycle strobe at the start of each low phase |
| scl_high_start | output | 1 | One-cycle strobe at the start of each high phase |

## Verification
The bench builds the block with its default 16-bit register width and 8-bit address. This allows prescaler values 0, 1 and up to 4, together with low and high counts up to 15, to be exercised with periods of a few hundred cycles. These settings cover all three stretch values, including zero counts where the stretch alone sets the phase length. They also allow mid-phase register writes to be placed at known points inside a phase.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  localparam logic [7:0] ADDR_LOW  = 8'h0C;
  localparam logic [7:0] ADDR_HIGH = 8'h10;
  localparam logic [7:0] ADDR_MODE = 8'h24;
  localparam logic [7:0] ADDR_PSC  = 8'h30;
  localparam int         RUN_BIT   = 5;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

  // Phase stretch chosen by the prescaler setting.
  function automatic logic [2:0] stretch_of(input logic psc_is0, input logic psc_is1);
    if (psc_is0)      return 3'd7;
    else if (psc_is1) return 3'd6;
    else              return 3'd5;
  endfunction
endpackage

// File: rtl/sclgen_regs.sv
module sclgen_regs #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] psc,
  output logic [DW-1:0] low_cnt,
  output logic [DW-1:0] high_cnt,
  output logic          run
);
  import sclgen_pkg::*;

  localparam logic [AW-1:0] A_LOW  = AW'(ADDR_LOW);
  localparam logic [AW-1:0] A_HIGH = AW'(ADDR_HIGH);
  localparam logic [AW-1:0] A_MODE = AW'(ADDR_MODE);
  localparam logic [AW-1:0] A_PSC  = AW'(ADDR_PSC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc      <= '0;
      low_cnt  <= '0;
      high_cnt <= '0;
      run      <= 1'b0;
    end else if (we) begin
      if (addr == A_PSC)  psc      <= wdata;
      if (addr == A_LOW)  low_cnt  <= wdata;
      if (addr == A_HIGH) high_cnt <= wdata;
      if (addr == A_MODE) run      <= wdata[RUN_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_PSC)       rdata = psc;
    else if (addr == A_LOW)  rdata = low_cnt;
    else if (addr == A_HIGH) rdata = high_cnt;
    else if (addr == A_MODE) rdata[RUN_BIT] = run;
  end
endmodule

// File: rtl/sclgen_prescale.sv
module sclgen_prescale #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  assign tick = !clear && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clear)       cnt <= '0;
    else if (cnt == div)  cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [DW-1:0] psc_r,
  input  logic [DW-1:0] low_r,
  input  logic [DW-1:0] high_r,
  output logic [DW-1:0] psc_s,
  output logic          idle,
  output logic          scl,
  output logic          lo_stb,
  output logic          hi_stb
);
  import sclgen_pkg::*;

  localparam int CW = DW + 1;

  phase_e        state;
  logic [DW-1:0] low_s, high_s;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len_now;
  logic [2:0]    d_s;

  assign d_s     = stretch_of(psc_s == '0, psc_s == DW'(1));
  assign len_now = CW'(state == PH_LOW ? low_s : high_s) + CW'(d_s);
  assign idle    = (state == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PH_IDLE;
      cnt    <= '0;
      psc_s  <= '0;
      low_s  <= '0;
      high_s <= '0;
      scl    <= 1'b1;
      lo_stb <= 1'b0;
      hi_stb <= 1'b0;
    end else begin
      lo_stb <= 1'b0;
      hi_stb <= 1'b0;
      if (state == PH_IDLE) begin
        scl    <= 1'b1;
        cnt    <= '0;
        psc_s  <= psc_r;
        low_s  <= low_r;
        high_s <= high_r;
        if (run) begin
          state  <= PH_LOW;
          scl    <= 1'b0;
          lo_stb <= 1'b1;
        end
      end else if (!run) begin
        state <= PH_IDLE;
        scl   <= 1'b1;
        cnt   <= '0;
      end else if (tick) begin
        if (cnt == len_now - 1'b1) begin
          cnt    <= '0;
          psc_s  <= psc_r;
          low_s  <= low_r;
          high_s <= high_r;
          if (state == PH_LOW) begin
            state  <= PH_HIGH;
            scl    <= 1'b1;
            hi_stb <= 1'b1;
          end else begin
            state  <= PH_LOW;
            scl    <= 1'b0;
            lo_stb <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          scl,
  output logic          scl_low_start,
  output logic          scl_high_start
);
  logic [DW-1:0] psc_r, low_r, high_r, psc_s;
  logic          run_en, tick, idle;

  sclgen_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .psc(psc_r), .low_cnt(low_r), .high_cnt(high_r), .run(run_en)
  );

  sclgen_prescale #(.DW(DW)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(idle), .div(psc_s), .tick(tick)
  );

  sclgen_phase #(.DW(DW)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run_en), .tick(tick),
    .psc_r(psc_r), .low_r(low_r), .high_r(high_r), .psc_s(psc_s), .idle(idle),
    .scl(scl), .lo_stb(scl_low_start), .hi_stb(scl_high_start)
  );
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic scl,
  input logic lo_stb,
  input logic hi_stb
);
  // R8: strobes never coincide
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lo_stb, hi_stb}));

  // R8: every falling serial clock edge is flagged as a low-phase start
  p_fall_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl) |-> lo_stb);

  // R8: a rise while running is flagged as a high-phase start
  p_rise_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl) && $past(run_en)) |-> hi_stb);

  // R4: a low-phase strobe comes with the line low
  p_low_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_stb |-> !scl);

  // R3: held off for two cycles means idle high without strobes
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !$past(run_en)) |-> (scl && !lo_stb && !hi_stb));
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .scl(scl),
  .lo_stb(scl_low_start), .hi_stb(scl_high_start)
);

// File: tb/test_scl_clkgen.sv
module test_scl_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        scl, scl_low_start, scl_high_start;

  int    tests = 0;
  int    fails = 0;
  bit    done = 1'b0;
  longint cyc = 0;

  localparam logic [7:0] A_LOW = 8'h0C, A_HIGH = 8'h10, A_MODE = 8'h24, A_PSC = 8'h30;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_clkgen i_scl_clkgen (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl(scl),
    .scl_low_start(scl_low_start), .scl_high_start(scl_high_start)
  );

  function automatic longint stretch(input int p);
    return (p == 0) ? 7 : (p == 1) ? 6 : 5;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_lo(output longint t);
    do @(negedge clk); while (!scl_low_start);
    t = cyc;
  endtask

  task automatic wait_hi(output longint t);
    do @(negedge clk); while (!scl_high_start);
    t = cyc;
  endtask

  task automatic run_cfg(input int p, input int lo, input int hi);
    longint t0, t1, t2, s, el, eh;
    wr(A_MODE, 16'h0000);
    wr(A_PSC, 16'(p));
    wr(A_LOW, 16'(lo));
    wr(A_HIGH, 16'(hi));
    wr(A_MODE, 16'h0020);
    wait_lo(t0);
    chk(scl == 1'b0, "R4 scl low at start", longint'(scl), 0);
    wait_hi(t1);
    chk(scl == 1'b1, "R8 scl high at high strobe", longint'(scl), 1);
    wait_lo(t2);
    s  = stretch(p);
    el = (lo + s) * (p + 1);
    eh = (hi + s) * (p + 1);
    chk(t1 - t0 == el, "R6 low phase length", t1 - t0, el);
    chk(t2 - t1 == eh, "R7 high phase length", t2 - t1, eh);
    chk(t2 - t0 == el + eh, "R5 period with stretch", t2 - t0, el + eh);
    wr(A_MODE, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    longint t0, t1, t2, t3;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R3: reset state
    rd(A_PSC, v);  chk(v == 0, "R1 reset psc", v, 0);
    rd(A_LOW, v);  chk(v == 0, "R1 reset low", v, 0);
    rd(A_HIGH, v); chk(v == 0, "R1 reset high", v, 0);
    rd(A_MODE, v); chk(v == 0, "R1 reset mode", v, 0);
    chk(scl && !scl_low_start && !scl_high_start, "R3 idle after reset", scl, 1);

    // R1 readback
    wr(A_PSC, 16'hA5C3); rd(A_PSC, v); chk(v == 16'hA5C3, "R1 psc readback", v, 16'hA5C3);
    wr(A_LOW, 16'h1234); rd(A_LOW, v); chk(v == 16'h1234, "R1 low readback", v, 16'h1234);
    wr(A_HIGH, 16'h00FE); rd(A_HIGH, v); chk(v == 16'h00FE, "R1 high readback", v, 16'h00FE);

    // R2: unmapped address and unstored mode bits
    wr(8'h14, 16'hFFFF);
    rd(8'h14, v);  chk(v == 0, "R2 unmapped read", v, 0);
    rd(A_PSC, v);  chk(v == 16'hA5C3, "R2 psc untouched", v, 16'hA5C3);
    rd(A_LOW, v);  chk(v == 16'h1234, "R2 low untouched", v, 16'h1234);
    rd(A_HIGH, v); chk(v == 16'h00FE, "R2 high untouched", v, 16'h00FE);
    wr(A_MODE, 16'hFFDF); rd(A_MODE, v); chk(v == 0, "R2 mode other bits", v, 0);

    // R3: held off, no activity
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!scl || scl_low_start || scl_high_start) quiet = 1'b0;
      end
      chk(quiet, "R3 held off stays high", quiet, 1);
    end

    // R5-R7 directed: each stretch value and zero counts
    run_cfg(0, 0, 0);
    run_cfg(1, 3, 5);
    run_cfg(2, 4, 1);
    run_cfg(0, 10, 2);
    run_cfg(4, 0, 7);

    // R5-R7 random
    for (int k = 0; k < 16; k++)
      run_cfg(int'($urandom_range(0, 4)), int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));

    // R9: mid-phase update takes effect at next boundary
    wr(A_PSC, 16'd0); wr(A_LOW, 16'd10); wr(A_HIGH, 16'd10);
    wr(A_MODE, 16'h0020);
    wait_lo(t0);
    @(negedge clk);
    wr(A_LOW, 16'd2);
    wr(A_HIGH, 16'd4);
    wait_hi(t1);
    wait_lo(t2);
    wait_hi(t3);
    chk(t1 - t0 == 17, "R9 current low unchanged", t1 - t0, 17);
    chk(t2 - t1 == 11, "R9 next high uses new count", t2 - t1, 11);
    chk(t3 - t2 == 9, "R9 next low uses new count", t3 - t2, 9);

    // R10: stop mid-phase
    wait_lo(t0);
    repeat (3) @(negedge clk);
    chk(scl == 1'b0, "R10 still low before stop", scl, 0);
    wr(A_MODE, 16'h0000);
    @(negedge clk);
    chk(scl == 1'b1, "R10 high two cycles after stop", scl, 1);
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!scl || scl_low_start || scl_high_start) quiet = 1'b0;
      end
      chk(quiet, "R3 idle after stop", quiet, 1);
    end

    // R4: restart begins with low phase
    wr(A_MODE, 16'h0020);
    wait_lo(t0);
    chk(scl == 1'b0, "R4 restart low", scl, 0);
    wr(A_MODE, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule